// File: doc/BRIEF.md
# Counter Overflow Interrupt Controller

This block gathers the single-cycle overflow pulses of a performance counter group into sticky status flags and raises one level-sensitive interrupt while any flag whose enable is set remains asserted. Two counter families feed it. The eight bandwidth counters occupy the low status bits. The sixteen general counters occupy the bits directly above them.

Software reaches the block through the same 32-bit register port that serves the counter bank. The interrupt mask is never written as a whole word. One register sets enable bits wherever a one is written. A second register clears enable bits wherever a one is written. The resulting mask can be read back from a third register. Flags are acknowledged by writing ones to a clear register, and the flag word itself is read from a status register. Reads are registered, so data appears one cycle after the read strobe.

Top module: `ovf_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every status bit, the interrupt output and the read data are zero.
- R2: A write to offset 0xCB8 sets each enable bit whose data bit is one and leaves every other enable bit unchanged, from the next cycle on.
- R3: A write to offset 0xCBC clears each enable bit whose data bit is one and leaves every other enable bit unchanged, from the next cycle on.
- R4: A read of offset 0xCC0 returns the enable mask in bits 23:0.
- R5: A pulse on bandwidth overflow input j sets status bit j. A pulse on general overflow input k sets status bit 8+k. A set bit stays set until it is cleared.
- R6: A write to offset 0xCC4 clears each status bit whose data bit is one. Writing 0xFFFFFF clears all 24 bits.
- R7: When an overflow pulse and a clear for the same bit fall in the same cycle, the status bit ends set.
- R8: The interrupt output in a cycle equals the OR over all bits of status AND enable as they stood in the previous cycle.
- R9: Writes to 0xCC0, 0xCC8 or any unmapped offset change neither the enable mask nor the status bits.
- R10: Read data updates one cycle after a read strobe and holds otherwise. Offset 0xCC8 returns status in bits 23:0. Unmapped offsets return zero. Bits 31:24 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 12 | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 12 | Read byte offset |
| rd_data_o | output | 32 | Registered read data |
| bw_ovf_i | input | 8 | Overflow pulses from the bandwidth counters |
| gen_ovf_i | input | 16 | Overflow pulses from the general counters |
| irq_o | output | 1 | Level interrupt |

## Verification
A flag or enable bit that is wrong inside the block reaches the ports in two ways. It flips the interrupt output on the following cycle whenever the matching bit on the other side is set. It also appears in the read data one cycle after the next read of the mask or status offset. The bench therefore interleaves reads of both offsets with overflow pulses, mask changes and clears. It compares the interrupt and the read data on every cycle against a behavioural model, so a divergence is reported within a cycle or two of the stimulus that exposes it. Cases where a clear and an overflow collide on the same bit, writes to read-only or unmapped offsets, and a long pseudo-random stretch are all included.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;

    // Register offsets decoded by software; kept fixed.
    localparam logic [11:0] OFS_EN_SET  = 12'hCB8;
    localparam logic [11:0] OFS_EN_DIS  = 12'hCBC;
    localparam logic [11:0] OFS_EN_READ = 12'hCC0;
    localparam logic [11:0] OFS_ST_CLR  = 12'hCC4;
    localparam logic [11:0] OFS_ST_READ = 12'hCC8;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_EN   = 2'd1,
        RSEL_ST   = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/ovf_reg_decode.sv
module ovf_reg_decode #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int N_ST   = 24
) (
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic [ADDR_W-1:0]     rd_addr_i,
    output logic [N_ST-1:0]       set_mask_o,
    output logic [N_ST-1:0]       dis_mask_o,
    output logic [N_ST-1:0]       clr_mask_o,
    output ovf_irq_pkg::rd_sel_e  rd_sel_o
);
    import ovf_irq_pkg::*;

    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_EN_DIS);
    localparam logic [ADDR_W-1:0] A_ENRD = ADDR_W'(OFS_EN_READ);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_ST_CLR);
    localparam logic [ADDR_W-1:0] A_STRD = ADDR_W'(OFS_ST_READ);

    logic [N_ST-1:0] wr_bits;
    assign wr_bits = wr_data_i[N_ST-1:0];

    always_comb begin
        set_mask_o = '0;
        dis_mask_o = '0;
        clr_mask_o = '0;
        if (wr_en_i) begin
            if (wr_addr_i == A_SET) set_mask_o = wr_bits;
            if (wr_addr_i == A_DIS) dis_mask_o = wr_bits;
            if (wr_addr_i == A_CLR) clr_mask_o = wr_bits;
        end
    end

    always_comb begin
        if (rd_addr_i == A_ENRD)      rd_sel_o = RSEL_EN;
        else if (rd_addr_i == A_STRD) rd_sel_o = RSEL_ST;
        else                          rd_sel_o = RSEL_NONE;
    end

    // A write reaches at most one of the three action groups.
    always_comb begin
        a_one_action_r9: assert ($countones({|set_mask_o, |dis_mask_o, |clr_mask_o}) <= 1);
    end

endmodule

// File: rtl/ovf_enable_mask.sv
module ovf_enable_mask #(
    parameter int N_ST = 24
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_ST-1:0] set_mask_i,
    input  logic [N_ST-1:0] dis_mask_i,
    output logic [N_ST-1:0] en_o
);
    typedef struct packed {
        logic [N_ST-1:0] en;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = (st_q.en | set_mask_i) & ~dis_mask_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign en_o = st_q.en;

    p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_mask_i != '0) |=> ((en_o & $past(set_mask_i)) == $past(set_mask_i)));

    p_dis_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dis_mask_i != '0) |=> ((en_o & $past(dis_mask_i)) == '0));

    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_mask_i == '0 && dis_mask_i == '0) |=> $stable(en_o));

endmodule

// File: rtl/ovf_status_bank.sv
module ovf_status_bank #(
    parameter int N_ST = 24
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_ST-1:0] ovf_i,
    input  logic [N_ST-1:0] clr_mask_i,
    output logic [N_ST-1:0] st_o
);
    typedef struct packed {
        logic [N_ST-1:0] flags;
    } st_state_t;

    st_state_t st_d, st_q;
    logic [N_ST-1:0] next_flags;

    // Per-bit sticky flag: a pulse in the clear cycle keeps the bit set.
    for (genvar i = 0; i < N_ST; i++) begin : g_flag
        assign next_flags[i] = ovf_i[i] | (st_q.flags[i] & ~clr_mask_i[i]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.flags = next_flags;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign st_o = st_q.flags;

    p_ovf_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_i != '0) |=> ((st_o & $past(ovf_i)) == $past(ovf_i)));

    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(st_o & ~clr_mask_i) & ~st_o) == '0));

    p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_mask_i != '0) |=> ((st_o & $past(clr_mask_i & ~ovf_i)) == '0));

    p_ovf_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((ovf_i & clr_mask_i) != '0) |=> ((st_o & $past(ovf_i & clr_mask_i)) == $past(ovf_i & clr_mask_i)));

endmodule

// File: rtl/ovf_irq_ctrl.sv
module ovf_irq_ctrl #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int N_BW   = 8,
    parameter int N_GEN  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [N_BW-1:0]   bw_ovf_i,
    input  logic [N_GEN-1:0]  gen_ovf_i,
    output logic              irq_o
);
    import ovf_irq_pkg::*;

    localparam int N_ST = N_BW + N_GEN;

    typedef struct packed {
        logic              irq;
        logic [DATA_W-1:0] rdata;
    } out_state_t;

    logic [N_ST-1:0] set_mask, dis_mask, clr_mask;
    logic [N_ST-1:0] en_vec, st_vec, ovf_vec;
    rd_sel_e         rd_sel;
    out_state_t      out_d, out_q;

    // General counters sit above the bandwidth counters.
    assign ovf_vec = {gen_ovf_i, bw_ovf_i};

    ovf_reg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_ST(N_ST)) i_decode (
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .set_mask_o(set_mask),
        .dis_mask_o(dis_mask),
        .clr_mask_o(clr_mask),
        .rd_sel_o  (rd_sel)
    );

    ovf_enable_mask #(.N_ST(N_ST)) i_enable (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_mask_i(set_mask),
        .dis_mask_i(dis_mask),
        .en_o      (en_vec)
    );

    ovf_status_bank #(.N_ST(N_ST)) i_status (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ovf_i     (ovf_vec),
        .clr_mask_i(clr_mask),
        .st_o      (st_vec)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = |(st_vec & en_vec);
        if (rd_en_i) begin
            out_d.rdata = '0;
            case (rd_sel)
                RSEL_EN: out_d.rdata[N_ST-1:0] = en_vec;
                RSEL_ST: out_d.rdata[N_ST-1:0] = st_vec;
                default: out_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign irq_o     = out_q.irq;
    assign rd_data_o = out_q.rdata;

    p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_vec & en_vec) != '0) |=> irq_o);

    p_irq_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_vec & en_vec) == '0) |=> !irq_o);

    p_upper_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_data_o[DATA_W-1:N_ST] == '0);

    p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: tb/test_ovf_irq_ctrl.sv
module test_ovf_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [7:0]  bw_ovf = '0;
    logic [15:0] gen_ovf = '0;
    logic [31:0] rd_data;
    logic        irq;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state
    logic [23:0] m_en = '0, m_st = '0;
    logic        m_irq = 1'b0;
    logic [31:0] m_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovf_irq_ctrl i_ovf_irq_ctrl (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .wr_en_i  (wr_en),
        .wr_addr_i(wr_addr),
        .wr_data_i(wr_data),
        .rd_en_i  (rd_en),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data),
        .bw_ovf_i (bw_ovf),
        .gen_ovf_i(gen_ovf),
        .irq_o    (irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = '0; m_st = '0; m_irq = 1'b0; m_rd = '0;
        end else begin
            logic [23:0] ov;
            ov = {gen_ovf, bw_ovf};
            m_irq = (m_st & m_en) != 24'd0;
            if (rd_en) begin
                if (rd_addr == 12'hCC0)      m_rd = {8'd0, m_en};
                else if (rd_addr == 12'hCC8) m_rd = {8'd0, m_st};
                else                         m_rd = '0;
            end
            if (wr_en && wr_addr == 12'hCC4) m_st = m_st & ~wr_data[23:0];
            m_st = m_st | ov;
            if (wr_en && wr_addr == 12'hCB8) m_en = m_en | wr_data[23:0];
            if (wr_en && wr_addr == 12'hCBC) m_en = m_en & ~wr_data[23:0];
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            cycles++;
            n_vec++;
            if (irq !== m_irq) begin
                n_bad++;
                $display("FAIL %s irq: got %0b expected %0b (cycle %0d)", cur_req, irq, m_irq, cycles);
            end
            if (rd_data !== m_rd) begin
                n_bad++;
                $display("FAIL %s rd_data: got %08h expected %08h (cycle %0d)", cur_req, rd_data, m_rd, cycles);
            end
            if (cycles > WATCHDOG) begin
                n_bad++;
                $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
                done = 1'b1;
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    task automatic drive(input bit we, input logic [11:0] wa, input logic [31:0] wd,
                         input bit re, input logic [11:0] ra,
                         input logic [7:0] bw, input logic [15:0] gen);
        @(negedge clk);
        #1;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra; bw_ovf = bw; gen_ovf = gen;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 12'h0, 32'h0, 0, 12'h0, 8'h0, 16'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        drive(1, a, d, 0, 12'h0, 8'h0, 16'h0);
    endtask

    task automatic rd(input logic [11:0] a);
        drive(0, 12'h0, 32'h0, 1, a, 8'h0, 16'h0);
        idle(1);
    endtask

    initial begin
        // R1: reset values observed while reset is held and right after release
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        rd(12'hCC0);
        rd(12'hCC8);

        // R5: general counter 3 sets bit 11, bandwidth counter 0 sets bit 0, both sticky
        cur_req = "R5";
        drive(0, 12'h0, 32'h0, 0, 12'h0, 8'h00, 16'h0008);
        drive(0, 12'h0, 32'h0, 0, 12'h0, 8'h01, 16'h0000);
        idle(3);
        rd(12'hCC8);

        // R2 / R4 / R8: enable bit 11 raises the interrupt one cycle after the mask lands
        cur_req = "R2";
        wr(12'hCB8, 32'h0000_0800);
        cur_req = "R8";
        idle(2);
        cur_req = "R4";
        rd(12'hCC0);
        cur_req = "R2";
        wr(12'hCB8, 32'h0000_0000);
        rd(12'hCC0);

        // R3: disabling bit 11 drops the interrupt; bit 0 still not enabled
        cur_req = "R3";
        wr(12'hCBC, 32'h0000_0800);
        idle(2);
        rd(12'hCC0);
        wr(12'hCB8, 32'h00FF_FFFF);
        wr(12'hCBC, 32'h0000_00F0);
        rd(12'hCC0);

        // R6: clear one flag, then clear all
        cur_req = "R6";
        wr(12'hCC4, 32'h0000_0800);
        rd(12'hCC8);
        drive(0, 12'h0, 32'h0, 0, 12'h0, 8'hAA, 16'h5555);
        rd(12'hCC8);
        wr(12'hCC4, 32'h00FF_FFFF);
        idle(2);
        rd(12'hCC8);

        // R7: overflow and clear of the same bit in one cycle
        cur_req = "R7";
        drive(0, 12'h0, 32'h0, 0, 12'h0, 8'h04, 16'h8000);
        drive(1, 12'hCC4, 32'h0080_0004, 0, 12'h0, 8'h04, 16'h8000);
        idle(1);
        rd(12'hCC8);

        // R9: writes to read-only and unmapped offsets do nothing
        cur_req = "R9";
        wr(12'hCC8, 32'hFFFF_FFFF);
        wr(12'hCC0, 32'h0000_0000);
        wr(12'hD00, 32'hFFFF_FFFF);
        wr(12'hCB4, 32'hFFFF_FFFF);
        rd(12'hCC8);
        rd(12'hCC0);

        // R10: unmapped read returns zero, upper bits zero, data holds without strobe
        cur_req = "R10";
        wr(12'hCB8, 32'hFFFF_FFFF);
        rd(12'hCC0);
        idle(3);
        rd(12'hC00);
        rd(12'hCC8);
        drive(0, 12'h0, 32'h0, 1, 12'hCC0, 8'hFF, 16'hFFFF);
        drive(0, 12'h0, 32'h0, 1, 12'hCC8, 8'h00, 16'h0000);
        idle(2);

        // R8: pseudo-random mix of all operations
        cur_req = "R8";
        begin
            int unsigned seed = 32'h1234_5678;
            for (int i = 0; i < 3000; i++) begin
                int unsigned r1, r2, r3;
                logic [11:0] a;
                seed = seed * 1664525 + 1013904223; r1 = seed;
                seed = seed * 1664525 + 1013904223; r2 = seed;
                seed = seed * 1664525 + 1013904223; r3 = seed;
                case (r1[2:0])
                    3'd0: a = 12'hCB8;
                    3'd1: a = 12'hCBC;
                    3'd2: a = 12'hCC0;
                    3'd3: a = 12'hCC4;
                    3'd4: a = 12'hCC8;
                    default: a = 12'hC00;
                endcase
                drive(r1[3], a, r2 & (r1[4] ? 32'hFFFF_FFFF : 32'h0000_0F0F),
                      r1[5], r1[6] ? 12'hCC8 : 12'hCC0,
                      r1[9:7] == 3'd0 ? r3[7:0] : 8'h0,
                      r1[12:10] == 3'd0 ? r3[23:8] : 16'h0);
            end
        end
        idle(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule